// File: doc/BRIEF.md
# Entropy Route and Mode Selector

This block sits between an entropy pipeline and its two consumers. For every seed it receives, it decides whether the seed goes to the hardware consumer port, goes to a firmware-readable data register, or is dropped. It also chooses whether the pipeline uses the hash conditioner or the bypass (boot-time) path. It asks a downstream cipher engine to halt while the hash conditioner is busy, which keeps the two engines from drawing peak power at the same time. It also reports when a graceful disable has fully drained.

The steering comes from several four-bit mode fields and one eight-bit one-time-programmable read enable. A four-bit field counts as true only when it equals `4'hA`; any other value, including damaged encodings, counts as false. The eight-bit enable counts as true only when it equals `8'hA5`. All decoded selects are registered. A seed takes the destination held in those registers in the cycle it is accepted. The hardware port uses a valid/ack handshake. A pending transfer holds off new seeds, and it delays the disable-done report until the consumer has acknowledged.

Top module: `entropy_route_sel`

## Requirements
- R1: When the FIPS field is not true, `sel_bypass` is 1 and `sel_hash` is 0 one cycle after the field is sampled.
- R2: The hash path is selected (`sel_hash`=1, `sel_bypass`=0) exactly when the FIPS field is true and the type and route fields are not both true. The same rule applies in firmware-insert mode.
- R3: While the route field is true, no accepted seed raises `hw_valid`. While it is false, an accepted seed raises `hw_valid` in the next cycle, carrying the seed's data.
- R4: An accepted seed produces a one-cycle `fw_valid` pulse, with its data on `fw_data`, only when the read enable equals `8'hA5` and both the data-register-enable and route fields are true. Otherwise `fw_valid` stays 0.
- R5: When the type and route fields are both true, the bypass path is selected and neither `hw_valid` nor `fw_valid` may result unless the R4 conditions also hold.
- R6: Once raised, `hw_valid` and `hw_data` hold until a cycle with `hw_ack`=1. While a transfer is pending, `seed_ready` is 0.
- R7: `halt_req` equals, one cycle later, the conditioner-busy input ANDed with hash-path selection and with insert mode being off.
- R8: While the firmware-insert field is true, `halt_req` stays 0 even when the hash conditioner is busy.
- R9: After `enable` falls, `disable_done` rises in the same cycle that the outstanding hardware transfer ends, or one cycle later if none is pending. It is never 1 while `hw_valid` is 1.
- R10: `disable_done` returns to 0 one cycle after `enable` rises again.
- R11: While `enable` is 0, `seed_ready` is 0 and offered seeds are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; falling starts a graceful disable |
| fips_mode | input | 4 | FIPS mode field (true = 4'hA) |
| ent_type | input | 4 | Entropy type field |
| ent_route | input | 4 | Route-to-firmware field |
| dreg_en | input | 4 | Data register enable field |
| fw_insert | input | 4 | Firmware insert mode field |
| otp_read_en | input | 8 | One-time-programmable read enable (true = 8'hA5) |
| cond_busy | input | 1 | Hash conditioner active |
| seed_valid | input | 1 | Incoming seed valid |
| seed_data | input | SEED_W | Incoming seed |
| seed_ready | output | 1 | Seed can be accepted this cycle |
| hw_ack | input | 1 | Hardware consumer acknowledge |
| hw_valid | output | 1 | Seed pending for hardware consumer |
| hw_data | output | SEED_W | Seed to hardware consumer |
| fw_valid | output | 1 | One-cycle firmware data strobe |
| fw_data | output | SEED_W | Seed for firmware data register |
| sel_hash | output | 1 | Hash conditioner path selected |
| sel_bypass | output | 1 | Bypass path selected |
| halt_req | output | 1 | Halt request to downstream cipher |
| disable_done | output | 1 | Graceful disable complete |

## Verification
All results appear one register stage after their cause. Path selects and halt come one cycle after the field or busy input they depend on. `hw_valid` and `fw_valid` come one cycle after the accepting edge. `disable_done` rises at the edge on which the last ack lands and falls one cycle after re-enable. The bench drives inputs on falling edges. It waits two falling edges after a mode change and reads outputs at the next falling edge after a seed, ack or busy input, so every sample follows the single edge that should update it. The hold cases sample several cycles in a row to show that nothing moves before the ack.

// File: rtl/ers_pkg.sv
package ers_pkg;

  localparam logic [3:0] MB4_TRUE = 4'hA;
  localparam logic [7:0] MB8_TRUE = 8'hA5;

  function automatic logic mb4_true(input logic [3:0] f);
    return f == MB4_TRUE;
  endfunction

  function automatic logic mb8_true(input logic [7:0] f);
    return f == MB8_TRUE;
  endfunction

  // hash path: FIPS on, and not both type and route set
  function automatic logic pick_hash(input logic fips, input logic typ, input logic route);
    return fips & ~(typ & route);
  endfunction

  function automatic logic hw_allowed(input logic route);
    return ~route;
  endfunction

  function automatic logic fw_allowed(input logic otp, input logic dreg, input logic route);
    return otp & dreg & route;
  endfunction

  function automatic logic want_halt(input logic busy, input logic hash, input logic ins);
    return busy & hash & ~ins;
  endfunction

endpackage

// File: rtl/ers_cfg_decode.sv
module ers_cfg_decode
  import ers_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] fips_mode,
  input  logic [3:0] ent_type,
  input  logic [3:0] ent_route,
  input  logic [3:0] dreg_en,
  input  logic [3:0] fw_insert,
  input  logic [7:0] otp_read_en,
  output logic       use_hash_q,
  output logic       hw_en_q,
  output logic       fw_en_q,
  output logic       insert_q
);

  logic fips_t, type_t, route_t, dreg_t, ins_t, otp_t;

  always_comb begin
    fips_t  = mb4_true(fips_mode);
    type_t  = mb4_true(ent_type);
    route_t = mb4_true(ent_route);
    dreg_t  = mb4_true(dreg_en);
    ins_t   = mb4_true(fw_insert);
    otp_t   = mb8_true(otp_read_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      use_hash_q <= 1'b0;
      hw_en_q    <= 1'b0;
      fw_en_q    <= 1'b0;
      insert_q   <= 1'b0;
    end else begin
      use_hash_q <= pick_hash(fips_t, type_t, route_t);
      hw_en_q    <= hw_allowed(route_t);
      fw_en_q    <= fw_allowed(otp_t, dreg_t, route_t);
      insert_q   <= ins_t;
    end
  end

endmodule

// File: rtl/ers_seed_steer.sv
module ers_seed_steer #(
  parameter int SEED_W = 384
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              hw_en,
  input  logic              fw_en,
  input  logic              seed_valid,
  input  logic [SEED_W-1:0] seed_data,
  output logic              seed_ready,
  input  logic              hw_ack,
  output logic              hw_valid,
  output logic [SEED_W-1:0] hw_data,
  output logic              fw_valid,
  output logic [SEED_W-1:0] fw_data,
  output logic              hw_pend_nx
);

  logic hw_pend_q;
  logic take;
  logic take_hw, take_fw;

  assign seed_ready = enable & ~hw_pend_q;
  assign take       = seed_valid & seed_ready;
  assign take_hw    = take & hw_en;
  assign take_fw    = take & fw_en;

  always_comb begin
    hw_pend_nx = hw_pend_q;
    if (take_hw)                hw_pend_nx = 1'b1;
    else if (hw_pend_q && hw_ack) hw_pend_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hw_pend_q <= 1'b0;
      hw_data   <= '0;
      fw_valid  <= 1'b0;
      fw_data   <= '0;
    end else begin
      hw_pend_q <= hw_pend_nx;
      if (take_hw) hw_data <= seed_data;
      fw_valid <= take_fw;
      if (take_fw) fw_data <= seed_data;
    end
  end

  assign hw_valid = hw_pend_q;

endmodule

// File: rtl/ers_halt_gen.sv
module ers_halt_gen
  import ers_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cond_busy,
  input  logic use_hash,
  input  logic insert_mode,
  output logic halt_req
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halt_req <= 1'b0;
    else        halt_req <= want_halt(cond_busy, use_hash, insert_mode);
  end

endmodule

// File: rtl/ers_shutdown.sv
module ers_shutdown (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic hw_pend_nx,
  output logic disable_done
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) disable_done <= 1'b0;
    else        disable_done <= ~enable & ~hw_pend_nx;
  end

endmodule

// File: rtl/entropy_route_sel.sv
module entropy_route_sel #(
  parameter int SEED_W = 384
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [3:0]        fips_mode,
  input  logic [3:0]        ent_type,
  input  logic [3:0]        ent_route,
  input  logic [3:0]        dreg_en,
  input  logic [3:0]        fw_insert,
  input  logic [7:0]        otp_read_en,
  input  logic              cond_busy,
  input  logic              seed_valid,
  input  logic [SEED_W-1:0] seed_data,
  output logic              seed_ready,
  input  logic              hw_ack,
  output logic              hw_valid,
  output logic [SEED_W-1:0] hw_data,
  output logic              fw_valid,
  output logic [SEED_W-1:0] fw_data,
  output logic              sel_hash,
  output logic              sel_bypass,
  output logic              halt_req,
  output logic              disable_done
);

  // named internal events, observed by the bound checker
  logic use_hash_q, hw_en_q, fw_en_q, insert_q;
  logic hw_pend_nx;

  ers_cfg_decode u_dec (
    .clk(clk), .rst_n(rst_n),
    .fips_mode(fips_mode), .ent_type(ent_type), .ent_route(ent_route),
    .dreg_en(dreg_en), .fw_insert(fw_insert), .otp_read_en(otp_read_en),
    .use_hash_q(use_hash_q), .hw_en_q(hw_en_q), .fw_en_q(fw_en_q),
    .insert_q(insert_q)
  );

  ers_seed_steer #(.SEED_W(SEED_W)) u_steer (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .hw_en(hw_en_q), .fw_en(fw_en_q),
    .seed_valid(seed_valid), .seed_data(seed_data), .seed_ready(seed_ready),
    .hw_ack(hw_ack), .hw_valid(hw_valid), .hw_data(hw_data),
    .fw_valid(fw_valid), .fw_data(fw_data), .hw_pend_nx(hw_pend_nx)
  );

  ers_halt_gen u_halt (
    .clk(clk), .rst_n(rst_n), .cond_busy(cond_busy),
    .use_hash(use_hash_q), .insert_mode(insert_q), .halt_req(halt_req)
  );

  ers_shutdown u_shut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .hw_pend_nx(hw_pend_nx), .disable_done(disable_done)
  );

  assign sel_hash   = use_hash_q;
  assign sel_bypass = ~use_hash_q;

endmodule

// File: rtl/entropy_route_sel_chk.sv
module entropy_route_sel_chk #(
  parameter int SEED_W = 384
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic [3:0]        fips_mode,
  input logic              seed_ready,
  input logic              hw_ack,
  input logic              hw_valid,
  input logic [SEED_W-1:0] hw_data,
  input logic              fw_valid,
  input logic              sel_bypass,
  input logic              halt_req,
  input logic              disable_done,
  input logic              hw_en_q,
  input logic              fw_en_q,
  input logic              insert_q
);

  p_fips_off_bypass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(fips_mode) != 4'hA) |-> sel_bypass);

  p_route_blocks_hw_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hw_valid) |-> $past(hw_en_q));

  p_fw_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fw_valid |-> $past(fw_en_q));

  p_hold_until_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_valid && !hw_ack) |=> (hw_valid && $stable(hw_data)));

  p_no_take_while_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hw_valid |-> !seed_ready);

  p_no_halt_insert_r8: assert property (@(posedge clk) disable iff (!rst_n)
    insert_q |=> !halt_req);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    disable_done |-> !hw_valid);

  p_done_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> !disable_done);

  p_ready_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !seed_ready);

endmodule

bind entropy_route_sel entropy_route_sel_chk #(.SEED_W(SEED_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .fips_mode(fips_mode),
  .seed_ready(seed_ready), .hw_ack(hw_ack), .hw_valid(hw_valid),
  .hw_data(hw_data), .fw_valid(fw_valid), .sel_bypass(sel_bypass),
  .halt_req(halt_req), .disable_done(disable_done),
  .hw_en_q(hw_en_q), .fw_en_q(fw_en_q), .insert_q(insert_q)
);

// File: tb/entropy_route_sel_tb.sv
`timescale 1ns/1ps
module entropy_route_sel_tb;

  localparam int SEED_W = 384;
  localparam logic [3:0] T = 4'hA;
  localparam logic [3:0] F = 4'h5;
  localparam logic [7:0] OT = 8'hA5;
  localparam logic [7:0] OF = 8'h00;

  // {fips, type, route, dreg, otp, exp_hash, exp_hw, exp_fw}
  localparam int NV = 10;
  localparam logic [26:0] VEC [NV] = '{
    {F,    F, F, F, OT, 3'b010},  // R1 bypass, hw
    {T,    F, F, F, OF, 3'b110},  // R2 hash, hw
    {T,    F, T, T, OT, 3'b101},  // R3 R4 route to fw
    {T,    T, T, T, OT, 3'b001},  // R5 bypass, fw only
    {T,    F, T, T, OF, 3'b100},  // R4 otp off -> dropped
    {T,    F, T, F, OT, 3'b100},  // R4 dreg off -> dropped
    {T,    T, F, F, OF, 3'b110},  // R2 type alone keeps hash
    {4'h3, F, F, F, OF, 3'b010},  // R1 damaged fips = false
    {T,    F, F, T, OT, 3'b110},  // R4 route off -> hw not fw
    {T,    T, T, F, OT, 3'b000}   // R5 nowhere
  };

  logic clk = 0, rst_n = 0, enable = 0;
  logic [3:0] fips_mode = F, ent_type = F, ent_route = F, dreg_en = F, fw_insert = F;
  logic [7:0] otp_read_en = OF;
  logic cond_busy = 0, seed_valid = 0, hw_ack = 0;
  logic [SEED_W-1:0] seed_data = '0;
  logic seed_ready, hw_valid, fw_valid, sel_hash, sel_bypass, halt_req, disable_done;
  logic [SEED_W-1:0] hw_data, fw_data;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  entropy_route_sel #(.SEED_W(SEED_W)) u_dut (.*);

  function automatic logic [SEED_W-1:0] pat(input int i);
    return {12{32'hC0DE0000 | 32'(i)}};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic setv(input logic [26:0] v);
    fips_mode = v[26:23]; ent_type = v[22:19]; ent_route = v[18:15];
    dreg_en = v[14:11]; otp_read_en = v[10:3];
  endtask

  task automatic nx(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    nx(2);
    // reset state
    chk("reset sel_hash", sel_hash, 0);
    chk("reset sel_bypass R1", sel_bypass, 1);
    chk("reset hw_valid", hw_valid, 0);
    chk("reset fw_valid", fw_valid, 0);
    chk("reset halt", halt_req, 0);
    chk("reset done", disable_done, 0);
    rst_n = 1;
    nx(2);
    chk("R9 idle disable done", disable_done, 1);
    enable = 1;
    nx(1);
    chk("R10 done clears", disable_done, 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      setv(VEC[i]);
      nx(2);
      chk($sformatf("R1 R2 R5 v%0d sel_hash", i), sel_hash, VEC[i][2]);
      chk($sformatf("R1 v%0d sel_bypass", i), sel_bypass, !VEC[i][2]);
      seed_valid = 1; seed_data = pat(i);
      nx(1);
      seed_valid = 0;
      chk($sformatf("R3 v%0d hw_valid", i), hw_valid, VEC[i][1]);
      chk($sformatf("R4 v%0d fw_valid", i), fw_valid, VEC[i][0]);
      if (VEC[i][1]) chk($sformatf("R3 v%0d hw_data", i), 32'(hw_data == pat(i)), 1);
      if (VEC[i][0]) chk($sformatf("R4 v%0d fw_data", i), 32'(fw_data == pat(i)), 1);
      if (hw_valid) begin
        hw_ack = 1; nx(1); hw_ack = 0;
      end else nx(1);
      chk($sformatf("R4 v%0d fw pulse ends", i), fw_valid, 0);
    end

    // R6 hold until ack
    setv(VEC[0]); nx(2);
    seed_valid = 1; seed_data = pat(40);
    nx(1);
    seed_data = pat(41);
    for (int k = 0; k < 3; k++) begin
      chk("R6 hold valid", hw_valid, 1);
      chk("R6 ready low", seed_ready, 0);
      chk("R6 data stable", 32'(hw_data == pat(40)), 1);
      nx(1);
    end
    seed_valid = 0; hw_ack = 1; nx(1); hw_ack = 0;
    chk("R6 released", hw_valid, 0);

    // R9 disable mid transfer
    seed_valid = 1; seed_data = pat(50); nx(1); seed_valid = 0;
    chk("R9 pending", hw_valid, 1);
    enable = 0;
    nx(3);
    chk("R9 waits for ack", disable_done, 0);
    chk("R9 still pending", hw_valid, 1);
    hw_ack = 1; nx(1); hw_ack = 0;
    chk("R9 transfer ended", hw_valid, 0);
    chk("R9 done with ack", disable_done, 1);

    // R11 seeds ignored while disabled
    seed_valid = 1; seed_data = pat(60);
    nx(1);
    chk("R11 ready low", seed_ready, 0);
    nx(1);
    seed_valid = 0;
    chk("R11 not taken", hw_valid, 0);
    enable = 1; nx(1);
    chk("R10 done clears", disable_done, 0);
    chk("R11 nothing captured", hw_valid, 0);

    // R7 halt follows busy on hash path
    setv(VEC[1]); nx(2);
    cond_busy = 1; nx(1);
    chk("R7 halt on", halt_req, 1);
    cond_busy = 0; nx(1);
    chk("R7 halt off", halt_req, 0);
    setv(VEC[0]); nx(2);
    cond_busy = 1; nx(1);
    chk("R7 no halt on bypass", halt_req, 0);
    cond_busy = 0;

    // R8 insert mode suppresses halt
    setv(VEC[1]); fw_insert = T; nx(2);
    chk("R2 insert keeps hash", sel_hash, 1);
    cond_busy = 1; nx(1);
    chk("R8 no halt in insert", halt_req, 0);
    nx(1);
    chk("R8 still no halt", halt_req, 0);
    cond_busy = 0; fw_insert = F;

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule